// File: doc/BRIEF.md
# I2C Bus Busy Monitor

This block observes the clock and data lines of a shared I2C bus on which several controllers may compete, and keeps two flags for the local controller: a busy flag that says another party holds the bus, and a sticky free-event flag that records a completed STOP. Both lines are brought into the local clock domain through a synchronizer chain. Line transitions are found by comparing each synchronized sample with the one before it.

When the controller is enabled, the busy flag does not start blank. On the first clock edge that sees the enable high, it is seeded from the present line levels. A separate validity output tells the controller whether the busy flag can be trusted yet. After seeding, a START or a data-low-while-clock-high level marks the bus busy, and a STOP marks it idle and raises the free event. Software clears the free event with a one-cycle pulse. Tracking runs for as long as the enable stays high. Dropping the enable holds every flag at zero, and raising it again reloads the busy flag from the line levels.

Top module: `i2c_busy_monitor`

## Requirements
- R1: `scl_sync` and `sda_sync` equal `scl_in` and `sda_in` delayed by SYNC_STAGES (default 2) rising clock edges.
- R2: While `enable` is low at a clock edge, `bb`, `bf` and `bb_valid` are 0 after that edge, whatever the bus does.
- R3: At the first edge that sees `enable` high, `bb` is loaded as 1 only if `sda_sync`=0 and `scl_sync`=1. The other three level pairs load 0. `bf` is loaded as 0.
- R4: `bb_valid` is 0 in the cycle in which `enable` first rises, and is 1 after the first edge that sees it high, for as long as it stays high.
- R5: A START (`sda_sync` going 1 to 0 while `scl_sync` is 1 in both samples) sets `bb` at the next edge.
- R6: `sda_sync`=0 while `scl_sync`=1 sets `bb` at the next edge, even without a preceding START.
- R7: A STOP (`sda_sync` going 0 to 1 while `scl_sync` is 1 in both samples) clears `bb` and sets `bf` at the next edge.
- R8: `bf` stays 1 until a `bf_clear` pulse, which clears it at the next edge.
- R9: When `bf_clear` and a STOP fall in the same cycle, `bf` ends up 1.
- R10: A synchronous active-high `rst` clears `bb`, `bf` and `bb_valid` and presets the synchronized lines to the idle level 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Controller enable; a rise seeds the busy flag |
| scl_in | input | 1 | Raw clock line level from the pad |
| sda_in | input | 1 | Raw data line level from the pad |
| bf_clear | input | 1 | One-cycle pulse that clears the free event |
| bb | output | 1 | Bus busy flag |
| bf | output | 1 | Sticky bus-free event flag |
| bb_valid | output | 1 | Busy flag has been seeded and can be trusted |
| scl_sync | output | 1 | Synchronized clock line level |
| sda_sync | output | 1 | Synchronized data line level |

## Verification
A STOP can reach the state logic in the same cycle as a software clear of the free event. In that case the free event must survive. The bench provokes this in a directed step by placing the `bf_clear` pulse on the exact edge at which the synchronized data rise is seen, and expects `bf` to read 1 afterwards. Random bursts of line toggling mixed with random clear pulses hit the same collision many more times. In those bursts a cycle-level reference model, built from the requirements, judges every edge.

// File: rtl/i2cbm_pkg.sv
package i2cbm_pkg;

  // Line conditions decoded from two consecutive synchronized samples
  typedef struct packed {
    logic start;     // data falls while clock stays high
    logic stop;      // data rises while clock stays high
    logic low_hold;  // data low while clock high (ack-like level)
  } bus_evt_t;

  localparam logic LINE_IDLE = 1'b1;

endpackage

// File: rtl/i2cbm_sync.sv
module i2cbm_sync #(
  parameter int   W       = 2,
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  localparam int BITS = STAGES * W;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) q <= {W{RST_VAL}};
        else     q <= d;
      end
    end else begin : g_chain
      logic [STAGES-1:0][W-1:0] pipe;
      always_ff @(posedge clk) begin
        if (rst) pipe <= {BITS{RST_VAL}};
        else     pipe <= {pipe[STAGES-2:0], d};
      end
      assign q = pipe[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/i2cbm_cond_detect.sv
module i2cbm_cond_detect
  import i2cbm_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     scl_s,
  input  logic     sda_s,
  output bus_evt_t evt
);

  logic scl_p;
  logic sda_p;
  logic clk_steady_hi;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_p <= LINE_IDLE;
      sda_p <= LINE_IDLE;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  assign clk_steady_hi = scl_s & scl_p;

  always_comb begin
    evt.start    = clk_steady_hi &  sda_p & ~sda_s;
    evt.stop     = clk_steady_hi & ~sda_p &  sda_s;
    evt.low_hold = scl_s & ~sda_s;
  end

endmodule

// File: rtl/i2cbm_state.sv
module i2cbm_state
  import i2cbm_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     enable,
  input  logic     scl_s,
  input  logic     sda_s,
  input  bus_evt_t evt,
  input  logic     bf_clear,
  output logic     bb,
  output logic     bf,
  output logic     bb_valid
);

  logic seed_now;
  logic seed_busy;

  assign seed_now  = enable & ~bb_valid;
  assign seed_busy = scl_s & ~sda_s;

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      bb       <= 1'b0;
      bf       <= 1'b0;
      bb_valid <= 1'b0;
    end else if (seed_now) begin
      bb       <= seed_busy;
      bf       <= 1'b0;
      bb_valid <= 1'b1;
    end else begin
      if (evt.stop) begin
        bb <= 1'b0;
        bf <= 1'b1;
      end else begin
        if (evt.start || evt.low_hold) bb <= 1'b1;
        if (bf_clear)                  bf <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/i2c_busy_monitor.sv
module i2c_busy_monitor
  import i2cbm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic scl_in,
  input  logic sda_in,
  input  logic bf_clear,
  output logic bb,
  output logic bf,
  output logic bb_valid,
  output logic scl_sync,
  output logic sda_sync
);

  localparam int LINES = 2;

  logic [LINES-1:0] lines_q;
  bus_evt_t         evt;

  i2cbm_sync #(.W(LINES), .STAGES(SYNC_STAGES), .RST_VAL(LINE_IDLE)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({scl_in, sda_in}),
    .q   (lines_q)
  );

  assign scl_sync = lines_q[1];
  assign sda_sync = lines_q[0];

  i2cbm_cond_detect u_cond (
    .clk   (clk),
    .rst   (rst),
    .scl_s (scl_sync),
    .sda_s (sda_sync),
    .evt   (evt)
  );

  i2cbm_state u_state (
    .clk      (clk),
    .rst      (rst),
    .enable   (enable),
    .scl_s    (scl_sync),
    .sda_s    (sda_sync),
    .evt      (evt),
    .bf_clear (bf_clear),
    .bb       (bb),
    .bf       (bf),
    .bb_valid (bb_valid)
  );

endmodule

// File: rtl/i2cbm_props.sv
module i2cbm_props (
  input logic clk,
  input logic rst,
  input logic enable,
  input logic bf_clear,
  input logic scl_sync,
  input logic sda_sync,
  input logic bb,
  input logic bf,
  input logic bb_valid
);

  // R2
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (!bb && !bf && !bb_valid));

  // R3
  seed_table_chk: assert property (@(posedge clk) disable iff (rst)
    (enable && !bb_valid) |=> (bb == ($past(scl_sync) && !$past(sda_sync)) && !bf));

  // R4
  valid_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (enable && !bb_valid) |=> bb_valid);

  // R6
  low_hold_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (enable && bb_valid && scl_sync && !sda_sync) |=> bb);

  // R7
  stop_frees_chk: assert property (@(posedge clk) disable iff (rst)
    (enable && bb_valid && scl_sync && $past(scl_sync) && !$past(sda_sync) && sda_sync)
      |=> (!bb && bf));

  // R8
  bf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (enable && bb_valid && bf && !bf_clear) |=> bf);

endmodule

bind i2c_busy_monitor i2cbm_props u_props (
  .clk      (clk),
  .rst      (rst),
  .enable   (enable),
  .bf_clear (bf_clear),
  .scl_sync (scl_sync),
  .sda_sync (sda_sync),
  .bb       (bb),
  .bf       (bf),
  .bb_valid (bb_valid)
);

// File: tb/i2c_busy_monitor_tb.sv
module i2c_busy_monitor_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enable = 1'b0;
  logic scl_in = 1'b1;
  logic sda_in = 1'b1;
  logic bf_clear = 1'b0;
  logic bb, bf, bb_valid, scl_sync, sda_sync;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  bit model_on = 1'b0;

  // reference model state
  logic m_sc1 = 1, m_sd1 = 1, m_sc2 = 1, m_sd2 = 1, m_scp = 1, m_sdp = 1;
  logic m_bb = 0, m_bf = 0, m_val = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_busy_monitor dut_i (
    .clk(clk), .rst(rst), .enable(enable), .scl_in(scl_in), .sda_in(sda_in),
    .bf_clear(bf_clear), .bb(bb), .bf(bf), .bb_valid(bb_valid),
    .scl_sync(scl_sync), .sda_sync(sda_sync)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // model of the requirements, advanced at every rising edge
  always @(posedge clk) begin
    logic stop_c, low_c;
    if (rst) begin
      m_sc1 = 1; m_sd1 = 1; m_sc2 = 1; m_sd2 = 1; m_scp = 1; m_sdp = 1;
      m_bb = 0; m_bf = 0; m_val = 0;
    end else begin
      stop_c = m_sc2 & m_scp & ~m_sdp & m_sd2;
      low_c  = m_sc2 & ~m_sd2;
      if (!enable) begin
        m_bb = 0; m_bf = 0; m_val = 0;
      end else if (!m_val) begin
        m_bb = m_sc2 & ~m_sd2; m_bf = 0; m_val = 1;
      end else if (stop_c) begin
        m_bb = 0; m_bf = 1;
      end else begin
        if (low_c) m_bb = 1;
        if (bf_clear) m_bf = 0;
      end
      m_scp = m_sc2; m_sdp = m_sd2;
      m_sc2 = m_sc1; m_sd2 = m_sd1;
      m_sc1 = scl_in; m_sd1 = sda_in;
    end
  end

  always @(negedge clk) begin
    if (model_on) begin
      check(scl_sync == m_sc2, "R1 scl_sync", scl_sync, m_sc2);
      check(sda_sync == m_sd2, "R1 sda_sync", sda_sync, m_sd2);
      check(bb == m_bb, "R5 R6 R7 bb", bb, m_bb);
      check(bf == m_bf, "R8 R9 bf", bf, m_bf);
      check(bb_valid == m_val, "R4 bb_valid", bb_valid, m_val);
    end
  end

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic seed_of(input logic scl, input logic sda);
    return scl & ~sda;
  endfunction

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234abcd));
    wait_n(3);
    // R10 reset state
    check(!bb && !bf && !bb_valid, "R10 flags after reset", {bb, bf, bb_valid}, 0);
    check(scl_sync && sda_sync, "R10 lines idle after reset", {scl_sync, sda_sync}, 3);
    rst = 1'b0;
    model_on = 1'b1;

    // R3 / R4 seeding table
    for (int k = 0; k < 4; k++) begin
      enable = 1'b0;
      scl_in = k[1]; sda_in = k[0];
      wait_n(4);
      enable = 1'b1;
      #1 check(bb_valid == 1'b0, "R4 invalid in enable cycle", bb_valid, 0);
      wait_n(1);
      check(bb == seed_of(k[1], k[0]), "R3 seed table", bb, seed_of(k[1], k[0]));
      check(bb_valid == 1'b1, "R4 valid after first edge", bb_valid, 1);
    end

    // R2 disabled ignores bus
    enable = 1'b0;
    for (int i = 0; i < 6; i++) begin
      sda_in = i[0]; scl_in = 1'b1;
      wait_n(1);
    end
    wait_n(3);
    check(!bb && !bf && !bb_valid, "R2 quiet while disabled", {bb, bf, bb_valid}, 0);

    // seed idle, then START
    scl_in = 1; sda_in = 1; wait_n(4);
    enable = 1; wait_n(2);
    check(bb == 0, "R3 idle seed", bb, 0);
    sda_in = 0; wait_n(2);
    check(bb == 0, "R5 not yet busy", bb, 0);
    wait_n(1);
    check(bb == 1, "R5 start sets busy", bb, 1);

    // STOP
    sda_in = 1; wait_n(3);
    check(bb == 0 && bf == 1, "R7 stop frees bus", {bb, bf}, 1);
    wait_n(5);
    check(bf == 1, "R8 bf sticky", bf, 1);
    bf_clear = 1; wait_n(1); bf_clear = 0;
    check(bf == 0, "R8 bf cleared", bf, 0);

    // R9 clear on the same edge as a STOP
    sda_in = 0; wait_n(4);
    sda_in = 1; wait_n(2);
    bf_clear = 1; wait_n(1); bf_clear = 0;
    check(bf == 1, "R9 stop beats clear", bf, 1);
    bf_clear = 1; wait_n(1); bf_clear = 0;

    // R6 data low held, clock rises without START
    enable = 0; scl_in = 0; sda_in = 1; wait_n(4);
    enable = 1; wait_n(2);
    check(bb == 0, "R3 seed sda1 scl0", bb, 0);
    sda_in = 0; wait_n(4);
    check(bb == 0, "R6 clock low no busy", bb, 0);
    scl_in = 1; wait_n(3);
    check(bb == 1, "R6 low level sets busy", bb, 1);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      if (($urandom % 4) == 0) scl_in = ~scl_in;
      if (($urandom % 3) == 0) sda_in = ~sda_in;
      bf_clear = (($urandom % 6) == 0);
      if (($urandom % 200) == 0) enable = ~enable;
      else if (!enable && ($urandom % 8) == 0) enable = 1;
      rst = (($urandom % 500) == 0);
      wait_n(1);
    end
    rst = 0; bf_clear = 0;
    wait_n(2);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule